// File: doc/BRIEF.md
# Timing Mode Controller

This block decides which operating state a digital PLL timing generator is in, and drives the loop control strobes that go with that state. There are four states. In free-running the output timing comes from the local master oscillator alone. In holdover the loop keeps the frequency it last held. In phase-offset correction the loop takes a one-time snapshot of the present offset between the output and the reference. In tracking the loop follows the reference. An external select input chooses between free-running operation and normal operation. In normal operation a reference-failure flag from a reference monitor moves the machine into holdover and back out of it automatically.

The loop never locks straight onto a reference. Every return to tracking goes through the one-cycle correction state, which captures the existing output-to-reference phase offset so that the output phase is kept and is not slewed toward the reference. After reset the machine always starts in holdover. The state and all four strobes come from flip-flops, and each strobe matches the registered state in the same cycle.

Top module: `tmc_mode_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are state 1 (holdover), `hold_freq_o`=1, and `use_master_o`, `capture_o` and `track_o` all 0.
- R2: With `mode_sel`=1 at a clock edge and `rst` low, the state after that edge is 0 (free-running) and `use_master_o`=1, whatever the previous state was.
- R3: In free-running with `mode_sel` held at 1, `ref_fail` has no effect: state stays 0 and `use_master_o` stays 1.
- R4: From holdover with `mode_sel`=0 and `ref_fail`=0, the next state is 2 (correction), and `capture_o` is high for that single cycle.
- R5: From correction with `mode_sel`=0 and `ref_fail`=0, the next state is 3 (tracking), with `track_o`=1.
- R6: In tracking with `mode_sel`=0, `ref_fail`=1 sends the machine to state 1 (holdover) on the next edge.
- R7: From free-running, `mode_sel` returning to 0 always leads to holdover (state 1) first, regardless of `ref_fail`.
- R8: The state output `state_o` is 2 bits wide, encoded as free-running=0, holdover=1, correction=2, tracking=3.
- R9: Exactly one of `use_master_o`, `hold_freq_o`, `capture_o`, `track_o` is high in every cycle, and it is the one that belongs to the current `state_o`.
- R10: In holdover with `mode_sel`=0, `ref_fail`=1 keeps the machine in holdover.
- R11: In correction with `mode_sel`=0, `ref_fail`=1 sends the machine back to holdover without entering tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 0 = normal operation with automatic holdover, 1 = free-running |
| ref_fail | input | 1 | Selected reference reported as disrupted |
| state_o | output | 2 | Current state (0 free-running, 1 holdover, 2 correction, 3 tracking) |
| use_master_o | output | 1 | Output timing from master oscillator only |
| hold_freq_o | output | 1 | Freeze loop frequency |
| capture_o | output | 1 | One-cycle strobe to latch the phase offset |
| track_o | output | 1 | Loop follows the reference |

## Verification
The bench targets these corner cases:
- A reference failure arriving during the single correction cycle. A design that ignored it would go on into tracking on a bad reference.
- A return from free-running while the reference is healthy. A design that took a shortcut would skip holdover and pass through correction or tracking one cycle early.
- A select change to free-running from each of the other three states. A missed case would leave the loop tracking or holding while the select asks for the master clock.
- Reset applied in the middle of a run with free-running selected. The machine must still land in holdover.

A long pseudo-random run after the directed cases catches any strobe that lags the state by one cycle or overlaps a neighbouring strobe.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  localparam int unsigned NUM_STATES = 4;
  localparam int unsigned STATE_W    = $clog2(NUM_STATES);

  typedef enum logic [STATE_W-1:0] {
    ST_FREERUN = 2'd0,
    ST_HOLD    = 2'd1,
    ST_CORRECT = 2'd2,
    ST_TRACK   = 2'd3
  } tmc_state_e;

  localparam tmc_state_e RESET_STATE = ST_HOLD;
endpackage

// File: rtl/tmc_next_state.sv
module tmc_next_state
  import tmc_pkg::*;
(
  input  tmc_state_e cur_i,
  input  logic       free_sel_i,
  input  logic       ref_bad_i,
  output tmc_state_e nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (free_sel_i) begin
      nxt_o = ST_FREERUN;
    end else begin
      unique case (cur_i)
        ST_FREERUN: nxt_o = ST_HOLD;
        ST_HOLD:    nxt_o = ref_bad_i ? ST_HOLD : ST_CORRECT;
        ST_CORRECT: nxt_o = ref_bad_i ? ST_HOLD : ST_TRACK;
        ST_TRACK:   nxt_o = ref_bad_i ? ST_HOLD : ST_TRACK;
        default:    nxt_o = ST_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/tmc_strobe_reg.sv
module tmc_strobe_reg
  import tmc_pkg::*;
#(
  parameter int unsigned N = NUM_STATES
) (
  input  logic         clk,
  input  logic         rst,
  input  tmc_state_e   nxt_i,
  output logic [N-1:0] strobe_o
);
  for (genvar g = 0; g < N; g++) begin : g_strobe
    localparam logic RST_VAL = (g == int'(RESET_STATE));
    always_ff @(posedge clk) begin
      if (rst) strobe_o[g] <= RST_VAL;
      else     strobe_o[g] <= (nxt_i == tmc_state_e'(g));
    end
  end
endmodule

// File: rtl/tmc_mode_ctrl.sv
module tmc_mode_ctrl
  import tmc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_sel,
  input  logic               ref_fail,
  output logic [STATE_W-1:0] state_o,
  output logic               use_master_o,
  output logic               hold_freq_o,
  output logic               capture_o,
  output logic               track_o
);
  tmc_state_e            state_q;
  tmc_state_e            state_d;
  logic [NUM_STATES-1:0] strobes;

  tmc_next_state u_next (
    .cur_i      (state_q),
    .free_sel_i (mode_sel),
    .ref_bad_i  (ref_fail),
    .nxt_o      (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= RESET_STATE;
    else     state_q <= state_d;
  end

  tmc_strobe_reg #(.N(NUM_STATES)) u_strobe (
    .clk      (clk),
    .rst      (rst),
    .nxt_i    (state_d),
    .strobe_o (strobes)
  );

  assign state_o      = state_q;
  assign use_master_o = strobes[ST_FREERUN];
  assign hold_freq_o  = strobes[ST_HOLD];
  assign capture_o    = strobes[ST_CORRECT];
  assign track_o      = strobes[ST_TRACK];
endmodule

// File: rtl/tmc_mode_ctrl_chk.sv
module tmc_mode_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       mode_sel,
  input logic       ref_fail,
  input logic [1:0] state_o,
  input logic       use_master_o,
  input logic       hold_freq_o,
  input logic       capture_o,
  input logic       track_o
);
  AST_RESET_TO_HOLD: assert property (@(posedge clk) rst |=> (state_o == 2'd1 && hold_freq_o)); // R1
  AST_FREE_SELECT: assert property (@(posedge clk) disable iff (rst) mode_sel |=> (state_o == 2'd0 && use_master_o)); // R2
  AST_HOLD_TO_CORRECT: assert property (@(posedge clk) disable iff (rst) (state_o == 2'd1 && !mode_sel && !ref_fail) |=> (state_o == 2'd2 && capture_o)); // R4
  AST_CORRECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) (state_o == 2'd2) |=> (state_o != 2'd2)); // R4
  AST_CORRECT_TO_TRACK: assert property (@(posedge clk) disable iff (rst) (state_o == 2'd2 && !mode_sel && !ref_fail) |=> track_o); // R5
  AST_TRACK_FAIL_HOLD: assert property (@(posedge clk) disable iff (rst) (state_o == 2'd3 && !mode_sel && ref_fail) |=> state_o == 2'd1); // R6
  AST_FREE_EXIT_HOLD: assert property (@(posedge clk) disable iff (rst) (state_o == 2'd0 && !mode_sel) |=> state_o == 2'd1); // R7
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst) $countones({use_master_o, hold_freq_o, capture_o, track_o}) == 1); // R9
  AST_CAPTURE_STATE: assert property (@(posedge clk) disable iff (rst) capture_o |-> state_o == 2'd2); // R9
  AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (rst) (state_o == 2'd1 && !mode_sel && ref_fail) |=> state_o == 2'd1); // R10
  AST_CORRECT_ABORT: assert property (@(posedge clk) disable iff (rst) (state_o == 2'd2 && !mode_sel && ref_fail) |=> state_o == 2'd1); // R11
endmodule

bind tmc_mode_ctrl tmc_mode_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .ref_fail(ref_fail),
  .state_o(state_o), .use_master_o(use_master_o), .hold_freq_o(hold_freq_o),
  .capture_o(capture_o), .track_o(track_o)
);

// File: tb/test_tmc_mode_ctrl.sv
module test_tmc_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_sel = 1'b0;
  logic       ref_fail = 1'b1;
  logic [1:0] state_o;
  logic       use_master_o, hold_freq_o, capture_o, track_o;

  int    n_checks = 0;
  int    n_fails  = 0;
  int    model    = 1;
  string cur_req  = "R1";

  always #4 clk = ~clk;

  tmc_mode_ctrl i_tmc_mode_ctrl (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .ref_fail(ref_fail),
    .state_o(state_o), .use_master_o(use_master_o), .hold_freq_o(hold_freq_o),
    .capture_o(capture_o), .track_o(track_o)
  );

  // behavioural reference: 0 free, 1 hold, 2 correction, 3 track
  always @(posedge clk) begin
    if (rst)           model = 1;
    else if (mode_sel) model = 0;
    else if (model == 0) model = 1;
    else if (ref_fail)   model = 1;
    else if (model == 1) model = 2;
    else                 model = 3;
  end

  task automatic check(input string req);
    logic [3:0] act, exp;
    n_checks++;
    if (int'(state_o) != model) begin
      n_fails++;
      $display("FAIL %s R8: state actual %0d expected %0d", req, state_o, model);
    end
    act = {track_o, capture_o, hold_freq_o, use_master_o};
    exp = 4'b0001 << model;
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s R9: strobes actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic f, input string req);
    mode_sel = s;
    ref_fail = f;
    cur_req  = req;
    @(negedge clk);
    check(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    step(0, 1, "R1");
    step(0, 0, "R1");
    rst = 1'b0;
    step(0, 1, "R10");
    step(0, 1, "R10");
    step(0, 0, "R4");
    step(0, 0, "R5");
    step(0, 0, "R5");
    step(0, 1, "R6");
    step(0, 0, "R4");
    step(0, 1, "R11");
    step(0, 0, "R4");
    step(0, 0, "R5");
    step(1, 0, "R2");
    step(1, 1, "R3");
    step(1, 0, "R3");
    step(1, 1, "R3");
    step(0, 0, "R7");
    step(0, 0, "R4");
    step(1, 0, "R2");
    step(0, 1, "R7");
    step(1, 1, "R2");
    step(0, 0, "R7");
    step(0, 0, "R4");
    step(1, 0, "R2");
    step(1, 0, "R3");
    rst = 1'b1;
    step(1, 0, "R1");
    rst = 1'b0;
    step(0, 0, "R4");
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] == 4'd0, lfsr[7:5] == 3'd0, "R9");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule